// File: doc/BRIEF.md
# Block-Transfer Configuration Target for a Two-Wire Bus

This block is a target on a two-wire serial bus (I2C, standard mode, up to 100 kbit/s). Through it a host loads and reads back a small bank of configuration bytes, such as divider and spread settings for a clock generator. The block oversamples SCL and SDA on its own system clock and finds start and stop conditions. It matches its 7-bit device address and then moves bytes between the bus and an external register file. The register file is reached through a parallel write strobe and a parallel read port.

Transfers use a block framing. In a write, the host sends two placeholder bytes after the address: a command byte and a byte count. Both are acknowledged and both are ignored. The data that follows always lands at register 0 and goes up from there. In a read, the target first sends the number of implemented registers, then registers 0, 1, 2 and onward. It keeps sending until the host answers a byte with a not-acknowledge. SDA is driven open-drain: `sda_oe` high pulls the line low. The block never holds SCL low.

Top module: `cfg_i2c_target`

## Requirements
- R1: SCL and SDA pass through a synchronizer of SYNC_STAGES flip-flops. A falling SDA while SCL is high starts a transaction from any state and releases SDA. A rising SDA while SCL is high returns the block to idle.
- R2: When the first byte after a start carries the device address DEV_ADDR in bits 7..1, the block pulls SDA low for the ninth clock. Bit 0 selects read (1) or write (0).
- R3: With any other address, the block does not drive SDA and issues no register write until the next start.
- R4: In a write, the command byte and the count byte are each acknowledged and have no effect. Data byte j (counting from 0) is written to register j. Every byte is acknowledged.
- R5: Data bytes beyond register NUM_REGS-1 are acknowledged and discarded, with no write strobe.
- R6: A read sends the byte NUM_REGS first, then the contents of register 0, register 1 and so on, MSB first, each taken from `reg_rdata` while `reg_raddr` selects that register.
- R7: After register NUM_REGS-1 a read wraps to register 0.
- R8: When the host answers a read byte with a not-acknowledge (SDA high in the ninth clock), the block releases SDA and leaves it released until the next start.
- R9: `sda_oe` changes only while the synchronized SCL is low.
- R10: `reg_we` is a single-cycle pulse, and `reg_waddr` is below NUM_REGS whenever it is high.
- R11: After reset `sda_oe` and `reg_we` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_waddr | output | AW | Register index for the write |
| reg_wdata | output | 8 | Byte to store |
| reg_raddr | output | AW | Register index being read |
| reg_rdata | input | 8 | Contents of register `reg_raddr` |

## Verification
At the end of each received byte, one SCL falling edge does two jobs in the same system clock. It fires the register write strobe and it starts pulling SDA low for the acknowledge. The slot index decides whether the strobe fires at all: placeholder byte, stored byte, or discarded overflow byte. The bench provokes this by writing the full bank and two extra bytes, plus a short burst, each with repeated starts and with stops. It judges the result from both sides: every ninth clock must read low, and the register file built in the bench must hold exactly the bytes computed for slots 0 to NUM_REGS-1, with the total strobe count matching.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_WR_BYTE,
    PH_WR_ACK,
    PH_RD_BYTE,
    PH_RD_ACK
  } phase_t;

  // Register index following idx, wrapping after last_idx.
  function automatic logic [7:0] idx_next(input logic [7:0] idx, input logic [7:0] last_idx);
    return (idx == last_idx) ? 8'd0 : idx + 8'd1;
  endfunction

  // Register slot addressed by the write byte at position pos (0 = command byte).
  function automatic logic [7:0] slot_of(input logic [7:0] pos);
    return pos - 8'd2;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign scl_p = scl_pipe[SYNC_STAGES];
  assign sda_p = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A,
  parameter int NUM_REGS = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [7:0]    reg_rdata,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [7:0]    reg_wdata,
  output logic [AW-1:0] reg_raddr,
  output logic          in_idle
);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);
  localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);
  localparam logic [7:0] POS_END  = 8'(NUM_REGS + 2);

  phase_t       phase;
  logic [3:0]   bitcnt;
  logic [7:0]   rx_sh;
  logic [7:0]   tx_sh;
  logic [7:0]   wpos;
  logic [AW-1:0] rptr;
  logic         rw_bit;
  logic         host_nack;
  logic         byte_done;
  logic         slot_live;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign slot_live = (wpos >= 8'd2) && (wpos < POS_END);
  assign in_idle   = (phase == PH_IDLE);
  assign reg_raddr = rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      wpos      <= '0;
      rptr      <= '0;
      rw_bit    <= 1'b0;
      host_nack <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              if (rx_sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw_bit <= rx_sh[0];
                phase  <= PH_ADDR_ACK;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          PH_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_bit) begin
                tx_sh  <= CNT_BYTE;
                sda_oe <= ~CNT_BYTE[7];
                rptr   <= '0;
                phase  <= PH_RD_BYTE;
              end else begin
                sda_oe <= 1'b0;
                wpos   <= '0;
                phase  <= PH_WR_BYTE;
              end
            end
          end
          PH_WR_BYTE: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              sda_oe <= 1'b1;
              phase  <= PH_WR_ACK;
              if (slot_live) begin
                reg_we    <= 1'b1;
                reg_waddr <= AW'(slot_of(wpos));
                reg_wdata <= rx_sh;
              end
              if (wpos < POS_END) wpos <= wpos + 8'd1;
            end
          end
          PH_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              phase  <= PH_WR_BYTE;
            end
          end
          PH_RD_BYTE: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                phase  <= PH_RD_ACK;
              end else begin
                sda_oe <= ~tx_sh[6];
                tx_sh  <= {tx_sh[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          PH_RD_ACK: begin
            if (scl_rise) begin
              host_nack <= sda_s;
            end else if (scl_fall) begin
              if (host_nack) begin
                phase <= PH_IDLE;
              end else begin
                tx_sh  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                rptr   <= AW'(idx_next(8'(rptr), LAST_IDX));
                bitcnt <= '0;
                phase  <= PH_RD_BYTE;
              end
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h5A,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [7:0]    reg_wdata,
  output logic [AW-1:0] reg_raddr,
  input  logic [7:0]    reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, in_idle;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_target_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .NUM_REGS(NUM_REGS),
    .AW      (AW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_s    (sda_s),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr),
    .in_idle  (in_idle)
  );

endmodule

// File: rtl/cfg_i2c_target_chk.sv
module cfg_i2c_target_chk #(
  parameter int NUM_REGS = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          in_idle,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_waddr,
  input logic [AW-1:0] reg_raddr
);
  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !in_idle));

  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> in_idle);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r5_waddr_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (int'(reg_waddr) < NUM_REGS));

  a_r7_raddr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(reg_raddr) < NUM_REGS);

endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .in_idle  (in_idle),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_waddr(reg_waddr),
  .reg_raddr(reg_raddr)
);

// File: tb/test_cfg_i2c_target.sv
`timescale 1ns/1ps
module test_cfg_i2c_target;
  localparam logic [6:0] DEV = 7'h5A;
  localparam int N = 8;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [2:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] mem [N];
  int checks = 0;
  int fails = 0;
  int we_cnt = 0;
  int oe_hits = 0;
  int bad_edge = 0;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_raddr];

  cfg_i2c_target #(.DEV_ADDR(DEV), .NUM_REGS(N)) i_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= 8'h00;
    end else if (reg_we) begin
      mem[reg_waddr] <= reg_wdata;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_we) we_cnt++;
      if (sda_oe) oe_hits++;
      if (sda_oe != oe_prev && scl_m) bad_edge++;
    end
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((i * 37 + k * 91) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(last);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int we_base;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(sda_oe == 1'b0, "R11 sda_oe after reset", int'(sda_oe), 0);
    chk(reg_we == 1'b0, "R11 reg_we after reset", int'(reg_we), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: every foreign address, both directions, must see no acknowledge
    oe_hits = 0;
    for (int a = 0; a < 128; a++) begin
      if (7'(a) != DEV) begin
        bus_start();
        put_byte({7'(a), 1'(a & 1)}, ack);
        chk(ack == 1'b0, "R3 foreign address nack", int'(ack), 0);
        put_byte(8'hFF, ack);
        bus_stop();
      end
    end
    chk(oe_hits == 0, "R3 SDA driven for foreign address", oe_hits, 0);
    chk(we_cnt == 0, "R3 register writes for foreign address", we_cnt, 0);

    for (int k = 0; k < 4; k++) begin
      we_base = we_cnt;
      bus_start();
      put_byte({DEV, 1'b0}, ack);
      chk(ack, "R2 write address ack", int'(ack), 1);
      put_byte(8'hC3, ack);
      chk(ack, "R4 command byte ack", int'(ack), 1);
      put_byte(8'h02, ack);
      chk(ack, "R4 count byte ack", int'(ack), 1);
      for (int i = 0; i < N; i++) begin
        put_byte(pat(k, i), ack);
        chk(ack, "R4 data byte ack", int'(ack), 1);
      end
      for (int i = 0; i < 2; i++) begin
        put_byte(8'hA5, ack);
        chk(ack, "R5 overflow byte ack", int'(ack), 1);
      end
      if (k % 2 == 0) bus_stop();
      repeat (4) @(negedge clk);
      chk(we_cnt - we_base == N, "R5 R10 write strobe count", we_cnt - we_base, N);
      for (int i = 0; i < N; i++)
        chk(mem[i] == pat(k, i), "R4 register content", int'(mem[i]), int'(pat(k, i)));

      // read back, possibly after a repeated start
      bus_start();
      put_byte({DEV, 1'b1}, ack);
      chk(ack, "R2 read address ack", int'(ack), 1);
      get_byte(v, 1'b0);
      chk(v == 8'(N), "R6 leading count byte", int'(v), N);
      for (int i = 0; i < N + 2; i++) begin
        get_byte(v, (i == N + 1));
        if (i < N)
          chk(v == pat(k, i), "R6 read data byte", int'(v), int'(pat(k, i)));
        else
          chk(v == pat(k, i - N), "R7 wrapped read byte", int'(v), int'(pat(k, i - N)));
      end
      oe_hits = 0;
      repeat (3 * Q) @(negedge clk);
      chk(oe_hits == 0, "R8 SDA released after host nack", oe_hits, 0);
      bus_stop();
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 SDA released after stop", int'(sda_oe), 0);
    end

    // R4: short burst rewrites only the leading registers
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h07, ack);
    put_byte(8'h07, ack);
    for (int i = 0; i < 3; i++) put_byte(8'hE0 + 8'(i), ack);
    bus_stop();
    repeat (4) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      v = (i < 3) ? 8'hE0 + 8'(i) : pat(3, i);
      chk(mem[i] == v, "R4 short burst content", int'(mem[i]), int'(v));
    end

    chk(bad_edge == 0, "R9 sda_oe changed while SCL high", bad_edge, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule